// File: doc/BRIEF.md
# Sample Rate Reducer for a Signed Converter Stream

This block sits between a 14-bit analog-to-digital converter that runs without pause at its full rate and the store that keeps acquired samples. A lower acquisition rate is never obtained by slowing the converter. The block instead turns every group of N input samples into stored words, which gives a stored rate of full rate divided by N. At 100 MS/s that is 10^8/N words per second. Input samples are two's-complement and arrive with a valid strobe. Cycles without the strobe do not count towards a group.

There are three reduction modes. Decimation keeps the first sample of each group of N. Averaging outputs the mean of the N samples in a group, truncated toward zero. Envelope mode covers twice as many samples per group (2N) and outputs two words per group: first the signed minimum, then the signed maximum, with a tag bit that tells them apart. This halves the pair rate compared with the other modes.

A controller holds the group counter and a two-state machine. In state COLLECT it is gathering a group. In state TAIL it still owes the maximum word of the envelope pair that has just finished. The transition COLLECT to TAIL happens on the last sample of an envelope group. TAIL returns to COLLECT on the next cycle, whether or not the owed word is sent. Changing the mode or N, or pulsing the restart input, discards any partial group.

Top module: `sr_reducer`

## Requirements
- R1: After reset, out_valid is low and stays low until samples are accepted.
- R2: With mode 2'b00 (decimate), the first accepted sample of each group of N is presented on out_data, with out_valid high, on the clock edge that follows its acceptance.
- R3: With mode 2'b01 (average), on the edge after the Nth accepted sample of a group, out_data carries the signed sum of the group divided by N, truncated toward zero.
- R4: With N equal to 1, decimate and average both reproduce every accepted sample unchanged, one cycle later.
- R5: With mode[1] set (envelope), each group of 2N accepted samples gives out_tag=0 with the signed minimum on the edge after the last sample, then out_tag=1 with the signed maximum on the next edge.
- R6: A ratio input of 0 behaves exactly like a ratio of 1.
- R7: Cycles with in_valid low neither advance a group nor produce a word (the owed maximum word of R5 excepted).
- R8: When mode or ratio differs from its value in the previous cycle, the partial group and any owed maximum word are dropped, and a sample accepted in that cycle starts a new group under the new setting.
- R9: A cycle with restart high ignores in_sample, drops the partial group and any owed maximum word, and is followed by out_valid low.
- R10: Averaging is exact for the largest N (255) with all samples at either extreme (-8192 or 8191).
- R11: out_tag is 0 on every word produced in decimate or average mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 14 | Two's-complement converter sample |
| ratio | input | 8 | Reduction factor N (0 treated as 1) |
| mode | input | 2 | 00 decimate, 01 average, 1x envelope |
| restart | input | 1 | Synchronous clear of the current group |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 14 | Reduced sample, minimum or maximum |
| out_tag | output | 1 | 1 marks the maximum word of an envelope pair |

## Verification
The hardest case to reach is an interrupted envelope pair: a restart or a setting change that lands exactly in the TAIL cycle, after the minimum word has been sent and while the maximum is still owed. Directed sequences use N equal to 1 and 2 so that group ends are cycle-exact and the disturbance can be put on that cycle. A seeded random phase then changes mode and ratio in mid-stream, drops the valid strobe at random, and pulses restart, so that such collisions also happen with ratios that were not planned.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        MODE_DECIM    = 2'b00,
        MODE_AVG      = 2'b01,
        MODE_PAIR     = 2'b10,
        MODE_PAIR_ALT = 2'b11
    } mode_e;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_TAIL    = 1'b1
    } state_e;

    function automatic logic is_pair(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               restart,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [1:0]         mode,
    output logic               take,
    output logic               first,
    output logic               last,
    output logic               tail_fire
);
    import sr_pkg::*;

    localparam int CNT_W = RATIO_W + 1;

    state_e             state, state_nxt;
    logic [RATIO_W-1:0] ratio_q;
    logic [1:0]         mode_q;
    logic [CNT_W-1:0]   cnt, cnt_base, cnt_nxt;
    logic [CNT_W-1:0]   n_eff, glen;
    logic               cfg_change;

    assign cfg_change = (ratio != ratio_q) || (mode != mode_q);
    assign n_eff      = (ratio == '0) ? CNT_W'(1) : CNT_W'(ratio);
    assign glen       = is_pair(mode) ? (n_eff << 1) : n_eff;
    assign cnt_base   = cfg_change ? '0 : cnt;

    // group position decode
    always_comb begin
        take      = in_valid && !restart;
        first     = take && (cnt_base == '0);
        last      = take && (cnt_base == glen - CNT_W'(1));
        tail_fire = (state == ST_TAIL) && !restart && !cfg_change;
    end

    // next state
    always_comb begin
        state_nxt = ST_COLLECT;
        unique case (state)
            ST_COLLECT: state_nxt = (last && is_pair(mode)) ? ST_TAIL : ST_COLLECT;
            ST_TAIL:    state_nxt = (last && is_pair(mode)) ? ST_TAIL : ST_COLLECT;
        endcase
    end

    always_comb begin
        if (restart)
            cnt_nxt = '0;
        else if (take)
            cnt_nxt = last ? '0 : cnt_base + CNT_W'(1);
        else
            cnt_nxt = cnt_base;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_COLLECT;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            ratio_q <= RATIO_W'(1);
            mode_q  <= 2'b00;
        end else begin
            cnt     <= cnt_nxt;
            ratio_q <= ratio;
            mode_q  <= mode;
        end
    end

endmodule

// File: rtl/sr_avg.sv
module sr_avg #(
    parameter int SAMPLE_W = 14,
    parameter int RATIO_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       first,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [RATIO_W-1:0]  ratio,
    output logic signed [SAMPLE_W-1:0] mean
);
    localparam int ACC_W = SAMPLE_W + RATIO_W;

    logic signed [ACC_W-1:0] acc, acc_sum, divisor;
    logic        [RATIO_W-1:0] n_eff;

    assign n_eff   = (ratio == '0) ? RATIO_W'(1) : ratio;
    assign divisor = $signed({{(ACC_W-RATIO_W){1'b0}}, n_eff});
    assign acc_sum = (first ? '0 : acc) + ACC_W'(sample);
    assign mean    = SAMPLE_W'(acc_sum / divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (take)
            acc <= acc_sum;
    end

endmodule

// File: rtl/sr_extreme.sv
module sr_extreme #(
    parameter int SAMPLE_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       first,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic signed [SAMPLE_W-1:0] lo_now,
    output logic signed [SAMPLE_W-1:0] hi_now
);
    logic signed [SAMPLE_W-1:0] lo_q, hi_q;

    assign lo_now = (first || sample < lo_q) ? sample : lo_q;
    assign hi_now = (first || sample > hi_q) ? sample : hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (take) begin
            lo_q <= lo_now;
            hi_q <= hi_now;
        end
    end

endmodule

// File: rtl/sr_reducer.sv
module sr_reducer #(
    parameter int SAMPLE_W = 14,
    parameter int RATIO_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [RATIO_W-1:0]  ratio,
    input  logic [1:0]          mode,
    input  logic                restart,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_tag
);
    import sr_pkg::*;

    logic                       take, first, last, tail_fire;
    logic signed [SAMPLE_W-1:0] mean, lo_now, hi_now, hi_hold;
    logic                       emit_d, tag_d, hold_load;
    logic        [SAMPLE_W-1:0] data_d;

    sr_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .restart(restart),
        .ratio(ratio), .mode(mode), .take(take), .first(first),
        .last(last), .tail_fire(tail_fire)
    );

    sr_avg #(.SAMPLE_W(SAMPLE_W), .RATIO_W(RATIO_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .take(take), .first(first),
        .sample($signed(in_sample)), .ratio(ratio), .mean(mean)
    );

    sr_extreme #(.SAMPLE_W(SAMPLE_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .take(take), .first(first),
        .sample($signed(in_sample)), .lo_now(lo_now), .hi_now(hi_now)
    );

    // output selection
    always_comb begin
        emit_d    = 1'b0;
        tag_d     = 1'b0;
        data_d    = in_sample;
        hold_load = 1'b0;
        unique case (mode_e'(mode))
            MODE_DECIM: begin
                emit_d = first;
            end
            MODE_AVG: begin
                emit_d = last;
                data_d = mean;
            end
            MODE_PAIR, MODE_PAIR_ALT: begin
                if (last) begin
                    emit_d    = 1'b1;
                    data_d    = lo_now;
                    hold_load = 1'b1;
                end
            end
        endcase
        if (!emit_d && tail_fire) begin
            emit_d = 1'b1;
            tag_d  = 1'b1;
            data_d = hi_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_tag   <= 1'b0;
            hi_hold   <= '0;
        end else begin
            out_valid <= emit_d;
            out_tag   <= tag_d;
            if (emit_d)
                out_data <= data_d;
            if (hold_load)
                hi_hold <= hi_now;
        end
    end

endmodule

// File: rtl/sr_reducer_chk.sv
module sr_reducer_chk #(
    parameter int SAMPLE_W = 14,
    parameter int RATIO_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [RATIO_W-1:0]  ratio,
    input logic [1:0]          mode,
    input logic                restart,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_data,
    input logic                out_tag
);
    a_r5_max_after_min: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag) |-> $past(out_valid && !out_tag));

    a_r11_tag_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag) |-> $past(mode[1]));

    a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !out_valid);

    a_r4_decim_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !restart && mode == 2'b00 && ratio <= 1)
        |=> (out_valid && out_data == $past(in_sample)));

    a_r4_avg_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !restart && mode == 2'b01 && ratio <= 1)
        |=> (out_valid && out_data == $past(in_sample)));

    a_r7_word_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tag) |-> $past(in_valid && !restart));
endmodule

bind sr_reducer sr_reducer_chk #(.SAMPLE_W(SAMPLE_W), .RATIO_W(RATIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .ratio(ratio), .mode(mode), .restart(restart), .out_valid(out_valid),
    .out_data(out_data), .out_tag(out_tag)
);

// File: tb/sr_reducer_bench.sv
module sr_reducer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic [7:0]  ratio = 8'd1;
    logic [1:0]  mode = 2'b00;
    logic        restart = 1'b0;
    logic        out_valid;
    logic [13:0] out_data;
    logic        out_tag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int m_cnt = 0, m_acc = 0, m_lo = 0, m_hi = 0, m_hold = 0;
    bit m_tail = 0;
    int m_ratio_q = 1, m_mode_q = 0;

    always #10 clk = ~clk;

    sr_reducer u_sr_reducer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ratio(ratio), .mode(mode), .restart(restart), .out_valid(out_valid),
        .out_data(out_data), .out_tag(out_tag)
    );

    function automatic int eff_n(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic step(input bit v, input int s, input int n, input int m,
                        input bit rs, input string tag);
        bit ev = 0;
        bit et = 0;
        int ed = 0;
        bit change;
        in_valid  = v;
        in_sample = 14'(s);
        ratio     = 8'(n);
        mode      = 2'(m);
        restart   = rs;
        change = (n != m_ratio_q) || (m != m_mode_q);
        if (rs) begin
            m_cnt = 0;
            m_tail = 0;
        end else begin
            if (m_tail && !change) begin
                ev = 1; ed = m_hold; et = 1;
            end
            m_tail = 0;
            if (change) m_cnt = 0;
            if (v) begin
                int gl;
                gl = (m >= 2) ? 2 * eff_n(n) : eff_n(n);
                if (m_cnt == 0) begin
                    m_acc = 0; m_lo = s; m_hi = s;
                end
                m_acc += s;
                if (s < m_lo) m_lo = s;
                if (s > m_hi) m_hi = s;
                if (m == 0 && m_cnt == 0) begin
                    ev = 1; ed = s; et = 0;
                end
                if (m == 1 && m_cnt == gl - 1) begin
                    ev = 1; ed = m_acc / eff_n(n); et = 0;
                end
                if (m >= 2 && m_cnt == gl - 1) begin
                    ev = 1; ed = m_lo; et = 0;
                    m_hold = m_hi; m_tail = 1;
                end
                m_cnt = (m_cnt == gl - 1) ? 0 : m_cnt + 1;
            end
        end
        m_ratio_q = n;
        m_mode_q = m;
        @(posedge clk);
        #1;
        total++;
        if (out_valid !== ev || (ev && ($signed(out_data) !== ed || out_tag !== et))) begin
            bad++;
            $display("FAIL %s: valid=%0b/%0b data=%0d/%0d tag=%0b/%0b",
                     tag, out_valid, ev, $signed(out_data), ed, out_tag, et);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: valid=%0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        // R1: idle input keeps output quiet
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R1");
        // R2 R11: decimate N=4 with gaps (R7)
        for (int i = 0; i < 24; i++) step(i % 3 != 2, i * 37 - 400, 4, 0, 0, "R2 R7 R11");
        // R4: N=1 pass-through
        for (int i = 0; i < 10; i++) step(1, 8191 - i * 1700, 1, 0, 0, "R4");
        for (int i = 0; i < 10; i++) step(1, -8192 + i * 1500, 1, 1, 0, "R4");
        // R6: ratio 0 behaves as 1
        for (int i = 0; i < 8; i++) step(1, i * 99 - 300, 0, 1, 0, "R6");
        for (int i = 0; i < 8; i++) step(1, i * 77 - 200, 0, 2, 0, "R6");
        // R3: negative means truncate toward zero
        for (int i = 0; i < 18; i++) step(1, (i % 2) ? -7 : -1, 3, 1, 0, "R3 R11");
        for (int i = 0; i < 8; i++) step(1, (i % 2) ? -7 : 0, 2, 1, 0, "R3");
        // R10: largest N at both extremes
        for (int i = 0; i < 255; i++) step(1, -8192, 255, 1, 0, "R10");
        for (int i = 0; i < 255; i++) step(1, 8191, 255, 1, 0, "R10");
        // R5: envelope, signed compare
        for (int i = 0; i < 24; i++) step(i % 5 != 4, (i * 2711) % 8000 - 4000, 3, 2, 0, "R5");
        for (int i = 0; i < 12; i++) step(1, (i % 2) ? -5 : 5, 1, 3, 0, "R5");
        // R8: setting change mid group and on the owed-max cycle
        step(1, 10, 4, 1, 0, "R8");
        step(1, 20, 4, 1, 0, "R8");
        for (int i = 0; i < 6; i++) step(1, 100 + i, 3, 1, 0, "R8");
        step(1, 3, 1, 2, 0, "R8");
        step(1, 9, 1, 2, 0, "R8");
        step(1, 50, 1, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        // R9: restart mid group and on the owed-max cycle
        step(1, 1, 4, 1, 0, "R9");
        step(1, 2, 4, 1, 0, "R9");
        step(1, 999, 4, 1, 1, "R9");
        for (int i = 0; i < 8; i++) step(1, 40 + i, 4, 1, 0, "R9");
        step(1, -3, 1, 2, 0, "R9");
        step(1, 4, 1, 2, 0, "R9");
        step(1, 7, 1, 2, 1, "R9");
        for (int i = 0; i < 6; i++) step(1, i, 1, 2, 0, "R9");
        // random mix
        begin
            int n = 2, m = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 59) == 0) begin
                    n = $urandom_range(0, 6);
                    m = $urandom_range(0, 3);
                end
                step($urandom_range(0, 3) != 0, int'($urandom_range(0, 16383)) - 8192,
                     n, m, $urandom_range(0, 99) == 0, "R2 R3 R5 R7 R8 R9");
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule